// File: doc/BRIEF.md
# Branch Target Instruction Cache

This block remembers the first few instructions found at the destination of recently taken direct branches. When fetch sees a branch that it predicts taken, it presents the branch's own address on the lookup port. On a hit the block hands back up to four 32-bit target instructions, so fetch can refill its queue one cycle sooner than a trip through the instruction cache would allow.

After a taken PC-relative branch has gone through the instruction cache, the fill port writes an entry. The fill supplies the branch address, the number of valid target instructions and the instructions themselves. Register-indirect branches are marked on the fill port and are never cached. Entries are keyed on the virtual address of the branch, not on the target. Whenever address mappings may change, a flush input clears the whole array.

The array has 32 sets of four ways. Within a set, ways are handed out in FIFO order by a per-set pointer.

Top module: `brt_cache`

## Requirements
- R1: The set index is lookup/fill address bits [6:2] and the tag is bits [31:7]. A lookup hits only when a valid way of that set holds an equal tag. Each set has four ways.
- R2: A fill stores its count field when that field is 1 to 4, and stores 4 for any larger value. A hit returns the stored count. Target instruction i sits at rsp_insn_o[32*i+31:32*i], and slots at index >= count read as zero.
- R3: Entries are keyed on the branch address. Two branches at different addresses that carry identical target instructions occupy separate entries, and each hits on its own.
- R4: A fill with fl_direct_i = 0 (register-indirect branch) or with a count of 0 changes nothing. A later lookup of that address still misses.
- R5: A fill whose tag misses in its set writes the way named by that set's 2-bit pointer and then advances the pointer by one, modulo 4. A fill whose tag matches a valid way rewrites that way and leaves the pointer alone. As a result, the fifth distinct tag filled into a set evicts the first.
- R6: A flush invalidates every entry and returns every set's pointer to way 0. A fill presented in the same cycle as a flush is discarded.
- R7: A lookup sampled at clock edge E produces exactly one response with rsp_valid_o = 1, visible after edge E+1, which is two cycles after the lookup is presented.
- R8: When a lookup and a fill reach the same set in the same cycle, the lookup answers from the contents before that fill.
- R9: A lookup sampled at the same edge as a flush, or one edge before it, produces no response.
- R10: While reset is asserted and right after it, rsp_valid_o and rsp_hit_o are 0 and every lookup misses.
- R11: A miss response has rsp_hit_o = 0, rsp_count_o = 0 and rsp_insn_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Invalidate all entries |
| lk_valid_i | input | 1 | Lookup request |
| lk_addr_i | input | 32 | Branch address to look up |
| fl_valid_i | input | 1 | Fill request |
| fl_direct_i | input | 1 | 1 = PC-relative branch, 0 = register-indirect |
| fl_addr_i | input | 32 | Address of the branch being filled |
| fl_count_i | input | 3 | Number of valid target instructions |
| fl_insn_i | input | 128 | Target instructions, slot i at bits [32i+31:32i] |
| rsp_valid_o | output | 1 | Response for a lookup two cycles earlier |
| rsp_hit_o | output | 1 | Lookup hit |
| rsp_count_o | output | 3 | Valid instruction count on hit |
| rsp_insn_o | output | 128 | Target instructions, unused slots zero |

## Verification
Directed sequences aim at specific behaviours. Some fill a single set with five distinct tags, so that FIFO eviction can be told apart from least-recently-used or random choice. Others refill a resident tag, which separates a rewrite in place from a fresh allocation. Same-address lookup-plus-fill cycles show whether a lookup returns old or new contents. Flushes timed one and zero cycles after a lookup show which lookups in flight are cancelled. A constrained random phase then mixes lookups, fills, indirect and zero-count fills and rare flushes over a few sets with few tags, so that hits, evictions and rewrites interleave. Every response is compared with a bench model.

// File: rtl/brt_cache_pkg.sv
package brt_cache_pkg;

    typedef enum logic [1:0] {
        FILL_NONE    = 2'd0,
        FILL_REWRITE = 2'd1,
        FILL_ALLOC   = 2'd2
    } fill_op_e;

    // A permitted fill either rewrites the matching way or allocates a new one.
    function automatic fill_op_e decide_fill(input logic go, input logic tag_hit);
        if (!go)
            return FILL_NONE;
        else if (tag_hit)
            return FILL_REWRITE;
        else
            return FILL_ALLOC;
    endfunction

endpackage

// File: rtl/brt_way_match.sv
module brt_way_match #(
    parameter  int WAYS  = 4,
    parameter  int TAG_W = 25,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [WAYS-1:0]            valid_i,
    input  logic [WAYS-1:0][TAG_W-1:0] tag_i,
    input  logic [TAG_W-1:0]           probe_i,
    output logic [WAYS-1:0]            hit_vec_o,
    output logic                       hit_o,
    output logic [WAY_W-1:0]           way_o
);

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec_o[w] = valid_i[w] && (tag_i[w] == probe_i);
    end

    always_comb begin
        hit_o = |hit_vec_o;
        way_o = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec_o[w]) way_o = WAY_W'(w);
        end
    end

    // R5: rewrite-in-place keeps one copy of a tag per set
    p_single_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec_o));

endmodule

// File: rtl/brt_store.sv
module brt_store #(
    parameter  int SETS   = 32,
    parameter  int WAYS   = 4,
    parameter  int TAG_W  = 25,
    parameter  int CNT_W  = 3,
    parameter  int LINE_W = 128,
    localparam int SET_W  = $clog2(SETS),
    localparam int WAY_W  = $clog2(WAYS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        flush_i,
    input  logic                        wr_en_i,
    input  logic                        wr_alloc_i,
    input  logic [SET_W-1:0]            wr_set_i,
    input  logic [WAY_W-1:0]            wr_way_i,
    input  logic [TAG_W-1:0]            wr_tag_i,
    input  logic [CNT_W-1:0]            wr_cnt_i,
    input  logic [LINE_W-1:0]           wr_line_i,
    input  logic [SET_W-1:0]            ra_set_i,
    output logic [WAYS-1:0]             ra_valid_o,
    output logic [WAYS-1:0][TAG_W-1:0]  ra_tag_o,
    output logic [WAYS-1:0][CNT_W-1:0]  ra_cnt_o,
    output logic [WAYS-1:0][LINE_W-1:0] ra_line_o,
    input  logic [SET_W-1:0]            rb_set_i,
    output logic [WAYS-1:0]             rb_valid_o,
    output logic [WAYS-1:0][TAG_W-1:0]  rb_tag_o,
    output logic [WAY_W-1:0]            rb_ptr_o
);

    typedef struct packed {
        logic [SETS-1:0][WAYS-1:0]             vld;
        logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  tag;
        logic [SETS-1:0][WAYS-1:0][CNT_W-1:0]  cnt;
        logic [SETS-1:0][WAYS-1:0][LINE_W-1:0] line;
        logic [SETS-1:0][WAY_W-1:0]            ptr;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (flush_i) begin
            st_d.vld = '0;
            st_d.ptr = '0;
        end else if (wr_en_i) begin
            st_d.vld[wr_set_i][wr_way_i]  = 1'b1;
            st_d.tag[wr_set_i][wr_way_i]  = wr_tag_i;
            st_d.cnt[wr_set_i][wr_way_i]  = wr_cnt_i;
            st_d.line[wr_set_i][wr_way_i] = wr_line_i;
            if (wr_alloc_i)
                st_d.ptr[wr_set_i] = st_q.ptr[wr_set_i] + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ra_valid_o = st_q.vld[ra_set_i];
    assign ra_tag_o   = st_q.tag[ra_set_i];
    assign ra_cnt_o   = st_q.cnt[ra_set_i];
    assign ra_line_o  = st_q.line[ra_set_i];
    assign rb_valid_o = st_q.vld[rb_set_i];
    assign rb_tag_o   = st_q.tag[rb_set_i];
    assign rb_ptr_o   = st_q.ptr[rb_set_i];

    // R5: an allocation moves that set's pointer on by one
    p_alloc_advances_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_alloc_i && !flush_i) |=>
            st_q.ptr[$past(wr_set_i)] == $past(st_q.ptr[wr_set_i]) + 1'b1);

    // R5: a rewrite in place leaves all pointers where they were
    p_rewrite_keeps_ptr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !wr_alloc_i && !flush_i) |=> $stable(st_q.ptr));

    // R6: nothing survives a flush
    p_flush_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (st_q.vld == '0 && st_q.ptr == '0));

endmodule

// File: rtl/brt_cache.sv
module brt_cache #(
    parameter  int ADDR_W  = 32,
    parameter  int SETS    = 32,
    parameter  int WAYS    = 4,
    parameter  int SLOTS   = 4,
    parameter  int INSN_W  = 32,
    parameter  int IDX_LSB = 2,
    localparam int SET_W   = $clog2(SETS),
    localparam int TAG_W   = ADDR_W - IDX_LSB - SET_W,
    localparam int WAY_W   = $clog2(WAYS),
    localparam int CNT_W   = $clog2(SLOTS + 1),
    localparam int LINE_W  = SLOTS * INSN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              lk_valid_i,
    input  logic [ADDR_W-1:0] lk_addr_i,
    input  logic              fl_valid_i,
    input  logic              fl_direct_i,
    input  logic [ADDR_W-1:0] fl_addr_i,
    input  logic [CNT_W-1:0]  fl_count_i,
    input  logic [LINE_W-1:0] fl_insn_i,
    output logic              rsp_valid_o,
    output logic              rsp_hit_o,
    output logic [CNT_W-1:0]  rsp_count_o,
    output logic [LINE_W-1:0] rsp_insn_o
);
    import brt_cache_pkg::*;

    // address split
    logic [SET_W-1:0] lk_set, fl_set;
    logic [TAG_W-1:0] lk_tag, fl_tag;
    assign lk_set = lk_addr_i[IDX_LSB +: SET_W];
    assign fl_set = fl_addr_i[IDX_LSB +: SET_W];
    assign lk_tag = lk_addr_i[ADDR_W-1 -: TAG_W];
    assign fl_tag = fl_addr_i[ADDR_W-1 -: TAG_W];

    // store read data
    logic [WAYS-1:0]             ra_valid, rb_valid;
    logic [WAYS-1:0][TAG_W-1:0]  ra_tag, rb_tag;
    logic [WAYS-1:0][CNT_W-1:0]  ra_cnt;
    logic [WAYS-1:0][LINE_W-1:0] ra_line;
    logic [WAY_W-1:0]            rb_ptr;

    // match results
    logic [WAYS-1:0]  la_vec, fb_vec;
    logic             la_hit, fb_hit;
    logic [WAY_W-1:0] la_way, fb_way;

    // fill control
    logic             fl_go;
    logic [CNT_W-1:0] fl_cnt_sat;
    fill_op_e         fl_op;
    logic             wr_en, wr_alloc;
    logic [WAY_W-1:0] wr_way;

    brt_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) i_lk_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid_i  (ra_valid),
        .tag_i    (ra_tag),
        .probe_i  (lk_tag),
        .hit_vec_o(la_vec),
        .hit_o    (la_hit),
        .way_o    (la_way)
    );

    brt_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) i_fl_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid_i  (rb_valid),
        .tag_i    (rb_tag),
        .probe_i  (fl_tag),
        .hit_vec_o(fb_vec),
        .hit_o    (fb_hit),
        .way_o    (fb_way)
    );

    always_comb begin
        fl_go      = fl_valid_i && fl_direct_i && (fl_count_i != '0) && !flush_i;
        fl_cnt_sat = (fl_count_i > CNT_W'(SLOTS)) ? CNT_W'(SLOTS) : fl_count_i;
        fl_op      = decide_fill(fl_go, fb_hit);
        wr_en      = (fl_op != FILL_NONE);
        wr_alloc   = (fl_op == FILL_ALLOC);
        wr_way     = fb_hit ? fb_way : rb_ptr;
    end

    brt_store #(
        .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .CNT_W(CNT_W), .LINE_W(LINE_W)
    ) i_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush_i   (flush_i),
        .wr_en_i   (wr_en),
        .wr_alloc_i(wr_alloc),
        .wr_set_i  (fl_set),
        .wr_way_i  (wr_way),
        .wr_tag_i  (fl_tag),
        .wr_cnt_i  (fl_cnt_sat),
        .wr_line_i (fl_insn_i),
        .ra_set_i  (lk_set),
        .ra_valid_o(ra_valid),
        .ra_tag_o  (ra_tag),
        .ra_cnt_o  (ra_cnt),
        .ra_line_o (ra_line),
        .rb_set_i  (fl_set),
        .rb_valid_o(rb_valid),
        .rb_tag_o  (rb_tag),
        .rb_ptr_o  (rb_ptr)
    );

    // two-stage lookup pipeline
    typedef struct packed {
        logic              s1_vld;
        logic              s1_hit;
        logic [CNT_W-1:0]  s1_cnt;
        logic [LINE_W-1:0] s1_line;
        logic              o_vld;
        logic              o_hit;
        logic [CNT_W-1:0]  o_cnt;
        logic [LINE_W-1:0] o_line;
    } pipe_t;

    pipe_t            p_d, p_q;
    logic [CNT_W-1:0] sel_cnt, eff_cnt;
    logic [LINE_W-1:0] sel_line;

    always_comb begin
        sel_cnt  = '0;
        sel_line = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (la_vec[w]) begin
                sel_cnt  = sel_cnt  | ra_cnt[w];
                sel_line = sel_line | ra_line[w];
            end
        end

        p_d         = p_q;
        p_d.s1_vld  = lk_valid_i && !flush_i;
        p_d.s1_hit  = lk_valid_i && la_hit;
        p_d.s1_cnt  = (lk_valid_i && la_hit) ? sel_cnt : '0;
        p_d.s1_line = (lk_valid_i && la_hit) ? sel_line : '0;

        eff_cnt     = (p_q.s1_vld && !flush_i) ? p_q.s1_cnt : '0;
        p_d.o_vld   = p_q.s1_vld && !flush_i;
        p_d.o_hit   = p_q.s1_vld && p_q.s1_hit && !flush_i;
        p_d.o_cnt   = eff_cnt;
        for (int s = 0; s < SLOTS; s++) begin
            p_d.o_line[s*INSN_W +: INSN_W] =
                (CNT_W'(s) < eff_cnt) ? p_q.s1_line[s*INSN_W +: INSN_W] : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign rsp_valid_o = p_q.o_vld;
    assign rsp_hit_o   = p_q.o_hit;
    assign rsp_count_o = p_q.o_cnt;
    assign rsp_insn_o  = p_q.o_line;

    // R7: every response traces back to a lookup two edges earlier
    p_rsp_follows_lookup_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> $past(lk_valid_i, 2));

    // R9: the edge after a flush never carries a response
    p_flush_kills_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(flush_i) |-> !rsp_valid_o);

    // R2: a hit always delivers between one and SLOTS instructions
    p_hit_count_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit_o |-> (rsp_valid_o && rsp_count_o != '0 && rsp_count_o <= CNT_W'(SLOTS)));

    // R11: a miss carries no payload
    p_miss_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && !rsp_hit_o) |-> (rsp_count_o == '0 && rsp_insn_o == '0));

endmodule

// File: tb/test_brt_cache.sv
`timescale 1ns/1ps
module test_brt_cache;

    localparam int NSETS = 32;
    localparam int NWAYS = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         flush_i = 1'b0;
    logic         lk_valid_i = 1'b0;
    logic [31:0]  lk_addr_i = '0;
    logic         fl_valid_i = 1'b0;
    logic         fl_direct_i = 1'b0;
    logic [31:0]  fl_addr_i = '0;
    logic [2:0]   fl_count_i = '0;
    logic [127:0] fl_insn_i = '0;
    logic         rsp_valid_o, rsp_hit_o;
    logic [2:0]   rsp_count_o;
    logic [127:0] rsp_insn_o;

    always #2.5 clk = ~clk;

    brt_cache i_brt_cache (
        .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
        .lk_valid_i(lk_valid_i), .lk_addr_i(lk_addr_i),
        .fl_valid_i(fl_valid_i), .fl_direct_i(fl_direct_i), .fl_addr_i(fl_addr_i),
        .fl_count_i(fl_count_i), .fl_insn_i(fl_insn_i),
        .rsp_valid_o(rsp_valid_o), .rsp_hit_o(rsp_hit_o),
        .rsp_count_o(rsp_count_o), .rsp_insn_o(rsp_insn_o)
    );

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    // reference model
    bit         m_v   [NSETS][NWAYS];
    bit [24:0]  m_tag [NSETS][NWAYS];
    bit [2:0]   m_cnt [NSETS][NWAYS];
    bit [127:0] m_dat [NSETS][NWAYS];
    bit [1:0]   m_ptr [NSETS];

    // expected pipeline
    bit e1_v, e1_h, eo_v, eo_h;
    bit [2:0] e1_c, eo_c;
    bit [127:0] e1_d, eo_d;
    string e1_r = "", eo_r = "";

    function automatic [31:0] mk_addr(input int tag, input int set);
        return {25'(tag), 5'(set), 2'b00};
    endfunction

    function automatic [127:0] mk_line(input int seed);
        bit [127:0] l;
        for (int i = 0; i < 4; i++) l[i*32 +: 32] = 32'(seed) * 32'h9E3779B1 + 32'(i);
        return l;
    endfunction

    task automatic model_lookup(input [31:0] a, output bit h, output bit [2:0] c,
                                output bit [127:0] d);
        int s = int'(a[6:2]);
        h = 0; c = 0; d = '0;
        for (int w = 0; w < NWAYS; w++) begin
            if (m_v[s][w] && m_tag[s][w] == a[31:7]) begin
                h = 1; c = m_cnt[s][w];
                for (int i = 0; i < 4; i++)
                    if (i < int'(c)) d[i*32 +: 32] = m_dat[s][w][i*32 +: 32];
            end
        end
    endtask

    task automatic model_fill(input [31:0] a, input [2:0] c, input [127:0] d);
        int s = int'(a[6:2]);
        int way = -1;
        bit [2:0] cs = (c > 3'd4) ? 3'd4 : c;
        for (int w = 0; w < NWAYS; w++)
            if (m_v[s][w] && m_tag[s][w] == a[31:7]) way = w;
        if (way < 0) begin
            way = int'(m_ptr[s]);
            m_ptr[s] = m_ptr[s] + 2'd1;
        end
        m_v[s][way] = 1; m_tag[s][way] = a[31:7];
        m_cnt[s][way] = cs; m_dat[s][way] = d;
    endtask

    task automatic check_out();
        n_checks++;
        if (rsp_valid_o !== eo_v || rsp_hit_o !== eo_h ||
            rsp_count_o !== eo_c || rsp_insn_o !== eo_d) begin
            n_fail++;
            $display("FAIL %s: got v=%0b h=%0b c=%0d d=%h expected v=%0b h=%0b c=%0d d=%h",
                     eo_r, rsp_valid_o, rsp_hit_o, rsp_count_o, rsp_insn_o,
                     eo_v, eo_h, eo_c, eo_d);
        end
    endtask

    task automatic step(input bit lv, input [31:0] la, input bit fv, input bit fd,
                        input [31:0] fa, input [2:0] fc, input [127:0] fi,
                        input bit fl, input string req);
        bit h; bit [2:0] c; bit [127:0] d;
        @(negedge clk);
        check_out();
        lk_valid_i = lv; lk_addr_i = la;
        fl_valid_i = fv; fl_direct_i = fd; fl_addr_i = fa;
        fl_count_i = fc; fl_insn_i = fi; flush_i = fl;
        // output stage
        if (!fl && e1_v) begin
            eo_v = 1; eo_h = e1_h; eo_c = e1_c; eo_d = e1_d; eo_r = e1_r;
        end else begin
            eo_v = 0; eo_h = 0; eo_c = 0; eo_d = '0;
        end
        // first stage, from pre-fill contents (R8)
        if (lv && !fl) begin
            model_lookup(la, h, c, d);
            e1_v = 1; e1_h = h; e1_c = c; e1_d = d; e1_r = req;
        end else begin
            e1_v = 0; e1_h = 0; e1_c = 0; e1_d = '0;
        end
        if (fl) begin
            foreach (m_v[s, w]) m_v[s][w] = 0;
            foreach (m_ptr[s]) m_ptr[s] = 0;
        end else if (fv && fd && fc != 0) begin
            model_fill(fa, fc, fi);
        end
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 0, 0, '0, 0, "");
    endtask

    task automatic look(input [31:0] a, input string req);
        step(1, a, 0, 0, 0, 0, '0, 0, req);
    endtask

    task automatic fill(input [31:0] a, input [2:0] c, input int seed);
        step(0, 0, 1, 1, a, c, mk_line(seed), 0, "");
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: got no completion expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        foreach (m_v[s, w]) m_v[s][w] = 0;
        foreach (m_ptr[s]) m_ptr[s] = 0;
        // R10: reset state
        repeat (3) @(negedge clk);
        check_out();
        rst_n = 1'b1;
        look(mk_addr(10, 3), "R10");
        idle(); idle();

        // R1 / R7 / R2: full entry
        fill(mk_addr(10, 3), 3'd4, 1);
        look(mk_addr(10, 3), "R7");
        look(mk_addr(11, 3), "R1");
        look(mk_addr(10, 4), "R1");
        // R2: partial and saturated counts
        fill(mk_addr(1, 4), 3'd2, 2);
        fill(mk_addr(2, 4), 3'd7, 3);
        look(mk_addr(1, 4), "R2");
        look(mk_addr(2, 4), "R2");
        // R3: two branches with identical targets
        fill(mk_addr(20, 5), 3'd3, 9);
        fill(mk_addr(21, 6), 3'd3, 9);
        look(mk_addr(20, 5), "R3");
        look(mk_addr(21, 6), "R3");
        // R4: indirect and zero-count fills ignored
        step(0, 0, 1, 0, mk_addr(30, 7), 3'd4, mk_line(4), 0, "");
        step(0, 0, 1, 1, mk_addr(31, 7), 3'd0, mk_line(5), 0, "");
        look(mk_addr(30, 7), "R4");
        look(mk_addr(31, 7), "R4");
        // R5: FIFO eviction and rewrite in place
        for (int t = 1; t <= 5; t++) fill(mk_addr(t, 9), 3'd4, 40 + t);
        for (int t = 1; t <= 5; t++) look(mk_addr(t, 9), "R5");
        fill(mk_addr(3, 9), 3'd1, 77);
        fill(mk_addr(6, 9), 3'd4, 78);
        for (int t = 2; t <= 6; t++) look(mk_addr(t, 9), "R5");
        // R8: same-cycle lookup and fill
        step(1, mk_addr(50, 11), 1, 1, mk_addr(50, 11), 3'd4, mk_line(80), 0, "R8");
        look(mk_addr(50, 11), "R8");
        // R9: flush cancels lookups in flight
        look(mk_addr(10, 3), "R9");
        step(1, mk_addr(10, 3), 0, 0, 0, 0, '0, 1, "R9");
        idle();
        // R6: flush empties, fill during flush discarded
        look(mk_addr(50, 11), "R6");
        step(0, 0, 1, 1, mk_addr(60, 12), 3'd4, mk_line(81), 1, "");
        look(mk_addr(60, 12), "R6");
        fill(mk_addr(61, 12), 3'd4, 82);
        look(mk_addr(61, 12), "R6");
        idle(); idle();

        // constrained random mix
        for (int i = 0; i < 4000; i++) begin
            bit lv = ($urandom % 10) < 7;
            bit fv = ($urandom % 2) == 1;
            bit fd = ($urandom % 8) != 0;
            bit fl = ($urandom % 64) == 0;
            int ls = int'($urandom % 8), lt = int'($urandom % 6);
            int fs = int'($urandom % 8), ft = int'($urandom % 6);
            step(lv, mk_addr(lt, ls), fv, fd, mk_addr(ft, fs), 3'($urandom % 6),
                 mk_line(int'($urandom % 1000)), fl, "R1");
        end
        idle(); idle(); idle();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule